// File: doc/BRIEF.md
# Interval Fairness Throttle Controller

This block closes a feedback loop on memory-system fairness by acting at the cores rather than at the shared memory. Once per interval, an upstream estimator hands it a snapshot. The snapshot holds a fixed-point slowdown estimate for every core, a software weight for every core, a square matrix of interference counts, a target and a mode. The block scales each slowdown by its weight. It picks the core with the largest weighted slowdown as the victim, and the core that caused that victim the most interference as the aggressor. It then decides whether the system is unfair enough to act on.

In ratio mode, unfairness is the largest weighted slowdown divided by the smallest. A sequential divider computes it in 8.8 fixed point, and the result is compared with the software target. In limit mode, the block acts when any core's weighted slowdown exceeds that core's own limit. When it acts, the aggressor moves one step down an 8-step throttle ladder and the victim moves one step up. Every step maps to an outstanding-request cap and an injection gap that the core-side request logic enforces.

The snapshot enters over a valid/ready handshake. Ready is high only while the block is idle. A snapshot is taken on the cycle both are high, and ready stays low until the decision has been applied. The producer must hold its data and valid until it is accepted, and any input values presented while ready is low play no part in any decision.

Top module: `src_throttle_ctrl`

## Requirements
- R1: After reset every core sits at level 7 (unthrottled), `est_ready` is high, each outstanding cap reads 16 and each injection gap reads 0.
- R2: A snapshot is accepted on a rising edge where `est_valid` and `est_ready` are both high. `est_ready` then stays low for exactly 25 cycles, and the new levels appear on the 25th rising edge after acceptance. Inputs that change while `est_ready` is low do not affect that decision.
- R3: Core i's weighted slowdown is (slowdown_i × weight_i) >> 4, saturated to 0xFFFF. Slowdown is 8.8 in bits [16i+15:16i], weight is 4.4 (0x10 = 1.0) in bits [8i+7:8i], and limit is 8.8 in bits [16i+15:16i].
- R4: The victim is the core with the largest weighted slowdown; on a tie the lowest index wins.
- R5: The aggressor is the column a with the largest count in the victim's row v of the matrix, taken from bits [(v·4+a)·8 +: 8]; on a tie the lowest a wins, and the diagonal takes part.
- R6: In ratio mode (`limit_mode`=0), unfairness is floor(max·256/min) saturated to 0xFFFF, and 0xFFFF when min is 0. The block acts only if unfairness is strictly greater than `target`.
- R7: In limit mode (`limit_mode`=1), the block acts only if some core's weighted slowdown is strictly greater than that core's limit, and `target` is not used.
- R8: When acting, the aggressor's level drops by one (floor 0) and the victim's rises by one (ceiling 7). All other cores keep their levels.
- R9: If the victim and the aggressor are the same core, no level changes.
- R10: If the condition to act is not met, no level changes.
- R11: For a core at level L, the outstanding cap is (L+1)·2 and the injection gap is (7−L)·4. Levels sit in bits [3i+2:3i], caps and gaps in bits [5i+4:5i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| est_valid | input | 1 | Snapshot valid |
| est_ready | output | 1 | Block idle and able to take a snapshot |
| limit_mode | input | 1 | 0: ratio against target, 1: per-core limits |
| target | input | 16 | Unfairness target, 8.8 |
| slowdown_flat | input | 64 | Per-core slowdown estimates, 8.8 |
| weight_flat | input | 32 | Per-core weights, 4.4 |
| limit_flat | input | 64 | Per-core slowdown limits, 8.8 |
| intf_flat | input | 128 | Interference matrix, row = victim, column = source |
| level_flat | output | 12 | Per-core throttle level |
| outlim_flat | output | 20 | Per-core outstanding-request cap |
| gap_flat | output | 20 | Per-core idle cycles between injections |

## Verification
The assertions assume that the producer keeps `est_valid` low, or keeps its data stable, until a snapshot is taken. They also assume that the only edge on which levels can move is the one that ends a busy period. From this they expect at most two cores to move per edge, each by a single step. The stimulus raises valid only after observing ready high and drops it on the cycle after acceptance. It disturbs data only inside busy windows, which keeps the handshake inside those assumptions while still showing that late data is ignored.

// File: rtl/sth_pkg.sv
package sth_pkg;
  typedef enum logic {ST_IDLE, ST_DIV} sth_state_e;
  localparam int UNF_FRAC = 8;
endpackage

// File: rtl/sth_weigh.sv
module sth_weigh #(
  parameter int NC = 4,
  parameter int SD_W = 16,
  parameter int WT_W = 8,
  parameter int WT_FRAC = 4,
  parameter int IM_W = 8,
  localparam int IX_W = (NC > 1) ? $clog2(NC) : 1
)(
  input  logic [NC*SD_W-1:0]    sd_flat,
  input  logic [NC*WT_W-1:0]    wt_flat,
  input  logic [NC*SD_W-1:0]    lim_flat,
  input  logic [NC*NC*IM_W-1:0] intf_flat,
  output logic [SD_W-1:0]       max_val,
  output logic [SD_W-1:0]       min_val,
  output logic [IX_W-1:0]       slow_idx,
  output logic [IX_W-1:0]       aggr_idx,
  output logic                  over_lim
);
  localparam int PW = SD_W + WT_W;
  logic [SD_W-1:0] ws [NC];

  for (genvar i = 0; i < NC; i++) begin : g_scale
    logic [PW-1:0] prod, shf;
    assign prod  = PW'(sd_flat[i*SD_W +: SD_W]) * PW'(wt_flat[i*WT_W +: WT_W]);
    assign shf   = prod >> WT_FRAC;
    assign ws[i] = (|shf[PW-1:SD_W]) ? {SD_W{1'b1}} : shf[SD_W-1:0];
  end

  always_comb begin
    max_val  = ws[0];
    min_val  = ws[0];
    slow_idx = '0;
    over_lim = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (ws[i] > max_val) begin
        max_val  = ws[i];
        slow_idx = IX_W'(i);
      end
      if (ws[i] < min_val) min_val = ws[i];
      if (ws[i] > lim_flat[i*SD_W +: SD_W]) over_lim = 1'b1;
    end
  end

  always_comb begin
    logic [IM_W-1:0] best, cur;
    best     = '0;
    aggr_idx = '0;
    for (int a = 0; a < NC; a++) begin
      cur = intf_flat[(int'(slow_idx)*NC + a)*IM_W +: IM_W];
      if (a == 0 || cur > best) begin
        best     = cur;
        aggr_idx = IX_W'(a);
      end
    end
  end
endmodule

// File: rtl/sth_divider.sv
module sth_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 16,
  localparam int CNT_W = $clog2(NUM_W)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W-1:0] rem, den_q;
  logic [DEN_W:0]   part, diff;
  logic             ge;

  assign part = {rem, quot[NUM_W-1]};
  assign ge   = part >= {1'b0, den_q};
  assign diff = part - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      den_q <= '0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run   <= 1'b1;
        cnt   <= '0;
        rem   <= '0;
        den_q <= den;
        quot  <= num;
      end else if (run) begin
        rem  <= ge ? diff[DEN_W-1:0] : part[DEN_W-1:0];
        quot <= {quot[NUM_W-2:0], ge};
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_W'(NUM_W-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sth_ladder.sv
module sth_ladder #(
  parameter int NC = 4,
  parameter int LEVELS = 8,
  parameter int OUT_STEP = 2,
  parameter int GAP_STEP = 4,
  localparam int IX_W  = (NC > 1) ? $clog2(NC) : 1,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int OUT_W = $clog2(LEVELS*OUT_STEP+1),
  localparam int GAP_W = $clog2((LEVELS-1)*GAP_STEP+1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [IX_W-1:0]       dn_idx,
  input  logic [IX_W-1:0]       up_idx,
  output logic [NC*LVL_W-1:0]   level_flat,
  output logic [NC*OUT_W-1:0]   outlim_flat,
  output logic [NC*GAP_W-1:0]   gap_flat
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS-1);

  for (genvar i = 0; i < NC; i++) begin : g_core
    logic [LVL_W-1:0] lvl;
    always_ff @(posedge clk) begin
      if (!rst_n) lvl <= TOP;
      else if (apply) begin
        if (dn_idx == IX_W'(i) && lvl != '0)       lvl <= lvl - 1'b1;
        else if (up_idx == IX_W'(i) && lvl != TOP) lvl <= lvl + 1'b1;
      end
    end
    assign level_flat[i*LVL_W +: LVL_W]  = lvl;
    assign outlim_flat[i*OUT_W +: OUT_W] = OUT_W'((int'(lvl) + 1) * OUT_STEP);
    assign gap_flat[i*GAP_W +: GAP_W]    = GAP_W'((LEVELS - 1 - int'(lvl)) * GAP_STEP);
  end
endmodule

// File: rtl/src_throttle_ctrl.sv
module src_throttle_ctrl
  import sth_pkg::*;
#(
  parameter int NC = 4,
  parameter int SD_W = 16,
  parameter int WT_W = 8,
  parameter int WT_FRAC = 4,
  parameter int IM_W = 8,
  parameter int LEVELS = 8,
  parameter int OUT_STEP = 2,
  parameter int GAP_STEP = 4,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int OUT_W = $clog2(LEVELS*OUT_STEP+1),
  localparam int GAP_W = $clog2((LEVELS-1)*GAP_STEP+1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  est_valid,
  output logic                  est_ready,
  input  logic                  limit_mode,
  input  logic [SD_W-1:0]       target,
  input  logic [NC*SD_W-1:0]    slowdown_flat,
  input  logic [NC*WT_W-1:0]    weight_flat,
  input  logic [NC*SD_W-1:0]    limit_flat,
  input  logic [NC*NC*IM_W-1:0] intf_flat,
  output logic [NC*LVL_W-1:0]   level_flat,
  output logic [NC*OUT_W-1:0]   outlim_flat,
  output logic [NC*GAP_W-1:0]   gap_flat
);
  localparam int IX_W  = (NC > 1) ? $clog2(NC) : 1;
  localparam int NUM_W = SD_W + UNF_FRAC;

  sth_state_e       state;
  logic [SD_W-1:0]  max_val, min_val, target_q, unf;
  logic [IX_W-1:0]  slow_c, aggr_c, slow_q, aggr_q;
  logic             over_c, over_q, mode_q;
  logic             accept, div_done, act, apply_go;
  logic [NUM_W-1:0] quot;

  sth_weigh #(.NC(NC), .SD_W(SD_W), .WT_W(WT_W), .WT_FRAC(WT_FRAC), .IM_W(IM_W)) u_weigh (
    .sd_flat(slowdown_flat), .wt_flat(weight_flat), .lim_flat(limit_flat),
    .intf_flat(intf_flat), .max_val(max_val), .min_val(min_val),
    .slow_idx(slow_c), .aggr_idx(aggr_c), .over_lim(over_c)
  );

  assign est_ready = (state == ST_IDLE);
  assign accept    = est_valid && est_ready;

  sth_divider #(.NUM_W(NUM_W), .DEN_W(SD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .num({max_val, {UNF_FRAC{1'b0}}}), .den(min_val),
    .done(div_done), .quot(quot)
  );

  assign unf      = (|quot[NUM_W-1:SD_W]) ? {SD_W{1'b1}} : quot[SD_W-1:0];
  assign act      = mode_q ? over_q : (unf > target_q);
  assign apply_go = (state == ST_DIV) && div_done && act && (slow_q != aggr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slow_q   <= '0;
      aggr_q   <= '0;
      over_q   <= 1'b0;
      mode_q   <= 1'b0;
      target_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_DIV;
          slow_q   <= slow_c;
          aggr_q   <= aggr_c;
          over_q   <= over_c;
          mode_q   <= limit_mode;
          target_q <= target;
        end
        ST_DIV: if (div_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  sth_ladder #(.NC(NC), .LEVELS(LEVELS), .OUT_STEP(OUT_STEP), .GAP_STEP(GAP_STEP)) u_ladder (
    .clk(clk), .rst_n(rst_n), .apply(apply_go), .dn_idx(aggr_q), .up_idx(slow_q),
    .level_flat(level_flat), .outlim_flat(outlim_flat), .gap_flat(gap_flat)
  );
endmodule

// File: rtl/sth_chk.sv
module sth_chk #(
  parameter int NC = 4,
  parameter int LVL_W = 3,
  parameter int NUM_W = 24
)(
  input logic               clk,
  input logic               rst_n,
  input logic               est_valid,
  input logic               est_ready,
  input logic [NC*LVL_W-1:0] level_flat
);
  logic [NC*LVL_W-1:0] prev_lvl;
  logic                prev_ready;
  logic [NC-1:0]       moved;
  int unsigned         busy_cnt;

  always_ff @(posedge clk) begin
    prev_lvl   <= level_flat;
    prev_ready <= est_ready;
    if (!rst_n || est_ready) busy_cnt <= 0;
    else                     busy_cnt <= busy_cnt + 1;
  end

  for (genvar i = 0; i < NC; i++) begin : g_mv
    logic [LVL_W:0] cur, old;
    assign cur      = {1'b0, level_flat[i*LVL_W +: LVL_W]};
    assign old      = {1'b0, prev_lvl[i*LVL_W +: LVL_W]};
    assign moved[i] = (cur != old);
    // R8: a level moves by at most one step per edge
    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == old) || (cur == old + 1'b1) || (cur + 1'b1 == old));
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && est_ready) |=> !est_ready);

  p_busy_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= NUM_W + 1);

  p_move_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|moved) |-> !prev_ready);

  p_two_movers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(moved) <= 2);
endmodule

bind src_throttle_ctrl sth_chk #(.NC(NC), .LVL_W(LVL_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .est_valid(est_valid), .est_ready(est_ready),
  .level_flat(level_flat)
);

// File: tb/src_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module src_throttle_ctrl_tb;
  localparam int NC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic est_valid = 1'b0, limit_mode = 1'b0;
  logic est_ready;
  logic [15:0] target = '0;
  logic [15:0] b_sd [NC];
  logic [7:0]  b_wt [NC];
  logic [15:0] b_lim [NC];
  logic [7:0]  b_im [NC][NC];
  logic [NC*16-1:0] sd_bus, lim_bus;
  logic [NC*8-1:0]  wt_bus;
  logic [NC*NC*8-1:0] im_bus;
  logic [NC*3-1:0] level_flat;
  logic [NC*5-1:0] outlim_flat, gap_flat;
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      sd_bus[i*16 +: 16] = b_sd[i];
      lim_bus[i*16 +: 16] = b_lim[i];
      wt_bus[i*8 +: 8] = b_wt[i];
      for (int a = 0; a < NC; a++) im_bus[(i*NC+a)*8 +: 8] = b_im[i][a];
    end
  end

  src_throttle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .est_valid(est_valid), .est_ready(est_ready),
    .limit_mode(limit_mode), .target(target), .slowdown_flat(sd_bus),
    .weight_flat(wt_bus), .limit_flat(lim_bus), .intf_flat(im_bus),
    .level_flat(level_flat), .outlim_flat(outlim_flat), .gap_flat(gap_flat)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_lvl [NC];
  int m_busy = 0;
  int m_up = 0, m_dn = 0;
  bit m_act = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) m_lvl[i] = 7;
      m_busy = 0; m_act = 0;
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0 && m_act) begin
        if (m_lvl[m_dn] > 0) m_lvl[m_dn]--;
        if (m_lvl[m_up] < 7) m_lvl[m_up]++;
      end
    end else if (est_valid) begin
      int w [NC];
      int mx, mn, v, ag, unf;
      bit over, trig;
      over = 0;
      for (int i = 0; i < NC; i++) begin
        w[i] = (int'(b_sd[i]) * int'(b_wt[i])) / 16;
        if (w[i] > 65535) w[i] = 65535;
        if (w[i] > int'(b_lim[i])) over = 1;
      end
      mx = w[0]; mn = w[0]; v = 0;
      for (int i = 1; i < NC; i++) begin
        if (w[i] > mx) begin mx = w[i]; v = i; end
        if (w[i] < mn) mn = w[i];
      end
      ag = 0;
      for (int a = 1; a < NC; a++) if (b_im[v][a] > b_im[v][ag]) ag = a;
      if (mn == 0) unf = 65535;
      else begin
        longint q;
        q = (longint'(mx) * 256) / mn;
        unf = (q > 65535) ? 65535 : int'(q);
      end
      trig = limit_mode ? over : (unf > int'(target));
      m_act = trig && (v != ag);
      m_up = v; m_dn = ag;
      m_busy = 25;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ready", int'(est_ready), int'(m_busy == 0));
      for (int i = 0; i < NC; i++) begin
        chk("R8 level", int'(level_flat[i*3 +: 3]), m_lvl[i]);
        chk("R11 cap", int'(outlim_flat[i*5 +: 5]), (m_lvl[i] + 1) * 2);
        chk("R11 gap", int'(gap_flat[i*5 +: 5]), (7 - m_lvl[i]) * 4);
      end
    end
  end

  function automatic int lv(int i);
    return int'(level_flat[i*3 +: 3]);
  endfunction

  task automatic set_uniform(logic [15:0] s0, logic [15:0] s1, logic [15:0] s2, logic [15:0] s3);
    b_sd[0] = s0; b_sd[1] = s1; b_sd[2] = s2; b_sd[3] = s3;
  endtask

  task automatic set_row(int v, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2, logic [7:0] a3);
    b_im[v][0] = a0; b_im[v][1] = a1; b_im[v][2] = a2; b_im[v][3] = a3;
  endtask

  task automatic submit(output int lat);
    @(negedge clk); est_valid = 1'b1;
    @(negedge clk); est_valid = 1'b0;
    lat = 0;
    while (!est_ready) begin lat++; @(negedge clk); end
  endtask

  initial begin
    int lat;
    for (int i = 0; i < NC; i++) begin
      b_sd[i] = 16'h0100; b_wt[i] = 8'h10; b_lim[i] = 16'hFFFF;
      for (int a = 0; a < NC; a++) b_im[i][a] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(est_ready), 1);
    for (int i = 0; i < NC; i++) begin
      chk("R1 level", lv(i), 7);
      chk("R1 cap", int'(outlim_flat[i*5 +: 5]), 16);
      chk("R1 gap", int'(gap_flat[i*5 +: 5]), 0);
    end

    // victim 1, aggressor 2 (tie 2/3)
    set_uniform(16'h0100, 16'h0300, 16'h0180, 16'h0100);
    set_row(1, 5, 0, 9, 9); target = 16'h0200;
    submit(lat);
    chk("R2 latency", lat, 25);
    chk("R5 aggressor down", lv(2), 6);
    chk("R8 victim saturates at top", lv(1), 7);

    set_row(1, 0, 20, 3, 3);
    submit(lat);
    chk("R9 same core", lv(2), 6);
    chk("R9 same core", lv(1), 7);

    set_row(1, 5, 0, 9, 9); target = 16'h0300;
    submit(lat);
    chk("R6 equal target", lv(2), 6);
    target = 16'h0400;
    submit(lat);
    chk("R10 below target", lv(2), 6);

    // weight lifts core 2 to victim
    set_uniform(16'h0100, 16'h0100, 16'h0100, 16'h0100);
    b_wt[2] = 8'h40; set_row(2, 0, 7, 0, 1); target = 16'h0200;
    submit(lat);
    chk("R3 weighted victim up", lv(2), 7);
    chk("R3 aggressor down", lv(1), 6);

    // all equal: ties
    b_wt[2] = 8'h10;
    set_uniform(16'h0200, 16'h0200, 16'h0200, 16'h0200);
    set_row(0, 0, 4, 4, 2); target = 16'h0080;
    submit(lat);
    chk("R4 tie victim 0", lv(0), 7);
    chk("R5 tie aggressor 1", lv(1), 5);

    // zero minimum
    set_uniform(16'h0100, 16'h0000, 16'h0100, 16'h0100);
    set_row(0, 0, 0, 0, 3); target = 16'hFFFE;
    submit(lat);
    chk("R6 zero min", lv(3), 6);

    // limit mode
    limit_mode = 1'b1; target = 16'h0000;
    for (int i = 0; i < NC; i++) b_lim[i] = 16'h0500;
    set_uniform(16'h0100, 16'h0100, 16'h0400, 16'h0100);
    set_row(2, 0, 0, 0, 9);
    submit(lat);
    chk("R7 under limits", lv(3), 6);
    b_lim[2] = 16'h03FF;
    submit(lat);
    chk("R7 over limit", lv(3), 5);
    for (int k = 0; k < 6; k++) submit(lat);
    chk("R8 floor", lv(3), 0);
    chk("R11 cap floor", int'(outlim_flat[3*5 +: 5]), 2);
    chk("R11 gap floor", int'(gap_flat[3*5 +: 5]), 28);

    // product saturation
    limit_mode = 1'b0; target = 16'h0200;
    set_uniform(16'hFFFF, 16'h0100, 16'h0100, 16'h0100);
    b_wt[0] = 8'hFF; set_row(0, 0, 0, 1, 0);
    submit(lat);
    chk("R3 saturation", lv(2), 6);

    // inputs changed while busy are ignored
    b_wt[0] = 8'h10;
    set_uniform(16'h0300, 16'h0100, 16'h0100, 16'h0100);
    set_row(0, 0, 5, 0, 0); set_row(3, 9, 0, 0, 0);
    @(negedge clk); est_valid = 1'b1;
    @(negedge clk); est_valid = 1'b0;
    set_uniform(16'h0100, 16'h0100, 16'h0100, 16'h0300);
    while (!est_ready) @(negedge clk);
    chk("R2 first snapshot used", lv(1), 4);
    chk("R2 late data ignored", lv(3), 0);
    chk("R2 late data ignored", lv(0), 7);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule